// File: doc/BRIEF.md
# Atomic Swap Memory Port

This block is a single-port, byte-addressed memory with 64-bit words, placed at a configurable base address inside a larger address map. It accepts one request per cycle. A request gives a command, an address, a size, write data and a compare value. The block serves plain reads and writes, invalidate-type commands that leave memory alone, unconditional atomic swaps, and compare-and-swap operations. Every atomic operation returns the word's contents from before the operation.

Each request also carries two flags. One asks for a response. The other says that another agent will answer the request; such a request is dropped without touching the array. An atomic operation reads in its accept cycle and writes in the cycle after. The block reports busy during that second cycle and ignores any request offered while busy. A one-cycle error flag marks these cases:

- commands the block does not support,
- out-of-range addresses,
- misaligned accesses,
- compare-and-swap requests of an illegal size.

Top module: `swapmem_port`

## Requirements
- R1: A read returns the addressed bytes right-justified in `rsp_data` one cycle after acceptance. The size code gives the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. The byte lane within the word is `req_addr[2:0]`, and bytes are little-endian.
- R2: A write changes only the bytes selected by size and address. All other bytes of the word keep their values.
- R3: A swap has command bit 3 set and bit 4 clear. It answers two cycles after acceptance, with the prior contents of the addressed bytes. It always stores the new value, and it answers with `rsp_stored` = 1.
- R4: A compare-and-swap has command bits 3 and 4 set. It stores the new value only when the prior contents equal `req_cmp`, masked to the size. `rsp_stored` shows whether it stored the value, and the prior contents are returned in both cases.
- R5: A compare-and-swap with size code 0 or 1 raises `err_flag` one cycle after acceptance and leaves memory unchanged.
- R6: A command with bit 2 set and bit 0 clear is an invalidate, with or without the write bit 1. It changes no memory. If a response is asked for, the response carries data 0. The invalidate check has priority over the write check.
- R7: A request with `req_inhibit` set is not accepted. It causes no memory change, no response and no error.
- R8: A command without bit 3 set raises `err_flag` in these cases: no bits set; bits 0 and 1 both set; bit 4 set. An error response carries data 0.
- R9: The word index is (`req_addr` - `BASE_ADDR`) / 8. An address below the base, or at or above base + 8*`DEPTH`, raises `err_flag` and changes no memory.
- R10: An address not aligned to the access size raises `err_flag` and changes no memory.
- R11: `busy` is high for exactly the one cycle after an atomic operation is accepted. A request offered while `busy` is high is ignored.
- R12: `rsp_valid` pulses only for requests that set `req_need_rsp`.
- R13: After reset, `busy`, `rsp_valid` and `err_flag` are low, and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_cmd | input | 5 | Command flags: bit0 read, bit1 write, bit2 invalidate, bit3 swap, bit4 conditional |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code (log2 of the byte count) |
| req_wdata | input | 64 | Write or swap data, right-justified |
| req_cmp | input | 64 | Compare value for compare-and-swap, right-justified |
| req_need_rsp | input | 1 | Request expects a response |
| req_inhibit | input | 1 | Another agent answers; drop the request |
| busy | output | 1 | Second cycle of an atomic operation |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 64 | Read data or prior contents, right-justified |
| rsp_stored | output | 1 | Atomic operation wrote memory |
| err_flag | output | 1 | One-cycle error pulse |

## Verification
The hardest situation to reach from the ports is a request that arrives during the busy cycle of an atomic operation. It must be ignored, while the swap still completes and answers. To reach it, the bench holds a write to a different word valid through the cycle that follows a swap's acceptance. It then reads that word back to show that the write never landed. A second hard case is an out-of-range write whose low bits alias a valid index. The bench places data at index 0 first, then sends the write just past the top of the range, so a missing range check would corrupt a known word.

// File: rtl/swapmem_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and lane helpers for the atomic swap memory port.
package swapmem_pkg;
    localparam int CMD_W  = 5;
    localparam int WORD_W = 64;
    localparam int LANES  = WORD_W / 8;

    // Command flag positions
    localparam int C_RD  = 0;
    localparam int C_WR  = 1;
    localparam int C_INV = 2;
    localparam int C_SWP = 3;
    localparam int C_CND = 4;

    typedef enum logic [2:0] {
        OP_READ, OP_WRITE, OP_NOP, OP_SWAP, OP_CSWAP, OP_BAD
    } op_e;

    // Data mask covering the bytes of one access size
    function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    // Byte-enable pattern of one access size, before lane shifting
    function automatic logic [LANES-1:0] size_be(input logic [1:0] sz);
        case (sz)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/swapmem_decode.sv
`timescale 1ns/1ps
// Request decoder: classifies the command, checks range, alignment and size
// legality, and forms the word index and byte lane.
// Assumes BASE_ADDR is 8-byte aligned and base + 8*DEPTH fits in ADDR_W bits.
module swapmem_decode
    import swapmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output op_e               kind,
    output logic              err,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        sh
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(DEPTH * 8);

    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic [2:0]        al_mask;
    logic              misaligned;

    // Offset from the base; wraps high for addresses below the base
    assign offset   = addr - BASE_ADDR;
    assign in_range = offset < SPAN;
    assign idx      = offset[3 +: IDX_W];
    assign sh       = addr[2:0];

    // Low address bits that must be zero for the given size
    always_comb begin
        case (size)
            2'd0:    al_mask = 3'b000;
            2'd1:    al_mask = 3'b001;
            2'd2:    al_mask = 3'b011;
            default: al_mask = 3'b111;
        endcase
    end
    assign misaligned = |(addr[2:0] & al_mask);

    // Command classification; invalidate is checked ahead of write
    always_comb begin
        if (cmd[C_SWP])
            kind = cmd[C_CND] ? OP_CSWAP : OP_SWAP;
        else if (cmd[C_CND])
            kind = OP_BAD;
        else if (cmd[C_RD])
            kind = cmd[C_WR] ? OP_BAD : OP_READ;
        else if (cmd[C_INV])
            kind = OP_NOP;
        else if (cmd[C_WR])
            kind = OP_WRITE;
        else
            kind = OP_BAD;
    end

    // Any reason to refuse the request
    assign err = (kind == OP_BAD) || !in_range || misaligned ||
                 ((kind == OP_CSWAP) && !size[1]);
endmodule

// File: rtl/swapmem_lanes.sv
`timescale 1ns/1ps
// Lane steering: extracts the addressed bytes of a word right-justified and
// positions write data with matching byte enables.
// Assumes the caller has already checked natural alignment.
module swapmem_lanes
    import swapmem_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        sh,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] sub,
    output logic [WORD_W-1:0] wr_word,
    output logic [LANES-1:0]  be
);
    logic [5:0] bit_sh;

    assign bit_sh  = {sh, 3'b000};
    assign sub     = (word >> bit_sh) & size_mask(size);
    assign wr_word = (wdata & size_mask(size)) << bit_sh;
    assign be      = size_be(size) << sh;
endmodule

// File: rtl/swapmem_array.sv
`timescale 1ns/1ps
// Storage: one byte-wide register array per lane, combinational read,
// byte-enabled synchronous write, cleared by reset.
// Assumes DEPTH stays small enough for flops.
module swapmem_array
    import swapmem_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [WORD_W-1:0]   rd_word,
    input  logic                we,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [LANES-1:0]    be,
    input  logic [WORD_W-1:0]   wr_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        // Clear on reset, else store this lane's byte when enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < int'(DEPTH); w++) lane_mem[w] <= '0;
            end else if (we && be[g]) begin
                lane_mem[wr_idx] <= wr_word[g*8 +: 8];
            end
        end

        assign rd_word[g*8 +: 8] = lane_mem[rd_idx];
    end
endmodule

// File: rtl/swapmem_port.sv
`timescale 1ns/1ps
// Atomic swap memory port: serves reads, writes, invalidates, swaps and
// compare-and-swaps on a 64-bit word array placed at BASE_ADDR.
// Atomic operations read in the accept cycle and write in the following
// busy cycle; requests offered while busy are ignored.
module swapmem_port
    import swapmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [4:0]          req_cmd,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [63:0]         req_wdata,
    input  logic [63:0]         req_cmp,
    input  logic                req_need_rsp,
    input  logic                req_inhibit,
    output logic                busy,
    output logic                rsp_valid,
    output logic [63:0]         rsp_data,
    output logic                rsp_stored,
    output logic                err_flag
);
    op_e                dec_kind;
    logic               dec_err;
    logic [IDX_W-1:0]   dec_idx;
    logic [2:0]         dec_sh;

    logic               busy_q, rsp_valid_q, stored_q, err_q;
    logic [WORD_W-1:0]  rsp_data_q;

    // Pending atomic operation
    logic [IDX_W-1:0]   p_idx;
    logic [2:0]         p_sh;
    logic [1:0]         p_size;
    logic [WORD_W-1:0]  p_wdata, p_cmp, old_q;
    logic               p_cond, p_need;

    logic               accept, take_atomic, match, do_write;
    logic [WORD_W-1:0]  arr_rd, l_word, l_wdata, sub, wr_word;
    logic [2:0]         l_sh;
    logic [1:0]         l_size;
    logic [LANES-1:0]   be;

    swapmem_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) dec_i (
        .cmd(req_cmd), .addr(req_addr), .size(req_size),
        .kind(dec_kind), .err(dec_err), .idx(dec_idx), .sh(dec_sh)
    );

    // Lane logic serves the request in the accept cycle, the pending op when busy
    assign l_word  = busy_q ? old_q   : arr_rd;
    assign l_sh    = busy_q ? p_sh    : dec_sh;
    assign l_size  = busy_q ? p_size  : req_size;
    assign l_wdata = busy_q ? p_wdata : req_wdata;

    swapmem_lanes lanes_i (
        .word(l_word), .sh(l_sh), .size(l_size), .wdata(l_wdata),
        .sub(sub), .wr_word(wr_word), .be(be)
    );

    assign accept      = req_valid && !busy_q && !req_inhibit;
    assign take_atomic = accept && !dec_err &&
                         (dec_kind == OP_SWAP || dec_kind == OP_CSWAP);
    assign match       = (sub == (p_cmp & size_mask(p_size)));
    assign do_write    = (accept && !dec_err && dec_kind == OP_WRITE) ||
                         (busy_q && (!p_cond || match));

    swapmem_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) arr_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(dec_idx), .rd_word(arr_rd),
        .we(do_write), .wr_idx(busy_q ? p_idx : dec_idx),
        .be(be), .wr_word(wr_word)
    );

    // Capture the atomic operation and the word it read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_idx <= '0; p_sh <= '0; p_size <= '0; p_wdata <= '0;
            p_cmp <= '0; old_q <= '0; p_cond <= 1'b0; p_need <= 1'b0;
        end else if (take_atomic) begin
            p_idx   <= dec_idx;
            p_sh    <= dec_sh;
            p_size  <= req_size;
            p_wdata <= req_wdata;
            p_cmp   <= req_cmp;
            old_q   <= arr_rd;
            p_cond  <= (dec_kind == OP_CSWAP);
            p_need  <= req_need_rsp;
        end
    end

    // Response, error and busy sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; rsp_valid_q <= 1'b0; stored_q <= 1'b0;
            err_q <= 1'b0; rsp_data_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            stored_q    <= 1'b0;
            err_q       <= 1'b0;
            if (busy_q) begin
                busy_q      <= 1'b0;
                rsp_valid_q <= p_need;
                rsp_data_q  <= sub;
                stored_q    <= p_need && (!p_cond || match);
            end else if (accept) begin
                if (dec_err) begin
                    err_q       <= 1'b1;
                    rsp_valid_q <= req_need_rsp;
                    rsp_data_q  <= '0;
                end else if (take_atomic) begin
                    busy_q <= 1'b1;
                end else begin
                    rsp_valid_q <= req_need_rsp;
                    rsp_data_q  <= (dec_kind == OP_READ) ? sub : '0;
                end
            end
        end
    end

    assign busy       = busy_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_data   = rsp_data_q;
    assign rsp_stored = stored_q;
    assign err_flag   = err_q;
endmodule

// File: rtl/swapmem_port_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for the atomic swap memory port.
// Assumes a synchronous active-low reset on rst_n.
module swapmem_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [4:0]  req_cmd,
    input logic        req_need_rsp,
    input logic        req_inhibit,
    input logic        busy,
    input logic        rsp_valid,
    input logic [63:0] rsp_data,
    input logic        rsp_stored,
    input logic        err_flag
);
    assert_inhibit_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_inhibit) |=> (!rsp_valid && !err_flag));

    assert_busy_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_busy_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(req_valid && req_cmd[3] && !req_inhibit));

    assert_no_unasked_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_inhibit && !req_need_rsp && !req_cmd[3])
        |=> !rsp_valid);

    assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && err_flag) |-> (rsp_data == 64'd0));

    assert_stored_has_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stored |-> (rsp_valid && !err_flag));

    assert_atomic_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !err_flag);
endmodule

bind swapmem_port swapmem_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_need_rsp(req_need_rsp), .req_inhibit(req_inhibit), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_stored(rsp_stored),
    .err_flag(err_flag)
);

// File: tb/swapmem_port_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the atomic swap memory port; one task per scenario.
module swapmem_port_tb_top;
    localparam logic [4:0] RD = 5'b00001, WR = 5'b00010, INV = 5'b00100,
                           WINV = 5'b00110, SWP = 5'b01000, CSWP = 5'b11000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_cmd = '0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0, req_cmp = '0;
    logic        req_need_rsp = 1'b0, req_inhibit = 1'b0;
    logic        busy, rsp_valid, rsp_stored, err_flag;
    logic [63:0] rsp_data;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    swapmem_port dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_cmp(req_cmp), .req_need_rsp(req_need_rsp),
        .req_inhibit(req_inhibit), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_stored(rsp_stored), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Offer one request for one cycle; returns at the negedge after acceptance
    task automatic send(input logic [4:0] c, input logic [15:0] a, input logic [1:0] s,
                        input logic [63:0] w, input logic [63:0] cm,
                        input logic need, input logic inh);
        @(negedge clk);
        req_cmd = c; req_addr = a; req_size = s; req_wdata = w; req_cmp = cm;
        req_need_rsp = need; req_inhibit = inh; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_inhibit = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] s, output logic [63:0] d);
        send(RD, a, s, '0, '0, 1'b1, 1'b0);
        d = rsp_data;
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] s, input logic [63:0] w);
        send(WR, a, s, w, '0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        chk("R13 busy", 64'(busy), 64'd0);
        chk("R13 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R13 err_flag", 64'(err_flag), 64'd0);
        rd(16'h1100, 2'd3, d);
        chk("R13 word zero", d, 64'd0);
    endtask

    task automatic t_read_write;
        logic [63:0] d;
        wr(16'h1008, 2'd3, 64'h1122_3344_5566_7788);
        rd(16'h1008, 2'd3, d);
        chk("R1 read 8B valid", 64'(rsp_valid), 64'd1);
        chk("R1 read 8B", d, 64'h1122_3344_5566_7788);
        wr(16'h1009, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB);
        rd(16'h1008, 2'd3, d);
        chk("R2 byte merge", d, 64'h1122_3344_5566_AB88);
        rd(16'h100A, 2'd1, d);
        chk("R1 read 2B", d, 64'h5566);
        rd(16'h100C, 2'd2, d);
        chk("R1 read 4B", d, 64'h1122_3344);
    endtask

    task automatic t_need;
        send(RD, 16'h1008, 2'd3, '0, '0, 1'b0, 1'b0);
        chk("R12 no rsp unasked", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_swap;
        logic [63:0] d;
        send(SWP, 16'h1008, 2'd3, 64'hDEAD_BEEF_0000_0001, '0, 1'b1, 1'b0);
        chk("R11 busy after swap", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R3 swap rsp", 64'(rsp_valid), 64'd1);
        chk("R3 swap old", rsp_data, 64'h1122_3344_5566_AB88);
        chk("R3 swap stored", 64'(rsp_stored), 64'd1);
        rd(16'h1008, 2'd3, d);
        chk("R3 swap new", d, 64'hDEAD_BEEF_0000_0001);
    endtask

    task automatic t_cswap;
        logic [63:0] d;
        wr(16'h1010, 2'd3, 64'h0000_0000_CAFE_F00D);
        send(CSWP, 16'h1010, 2'd2, 64'h1, 64'h1234_5678, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 miss old", rsp_data, 64'hCAFE_F00D);
        chk("R4 miss not stored", 64'(rsp_stored), 64'd0);
        rd(16'h1010, 2'd3, d);
        chk("R4 miss unchanged", d, 64'h0000_0000_CAFE_F00D);
        send(CSWP, 16'h1010, 2'd2, 64'h55AA_55AA, 64'hCAFE_F00D, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 hit stored", 64'(rsp_stored), 64'd1);
        send(CSWP, 16'h1014, 2'd2, 64'h77, 64'h0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 upper hit stored", 64'(rsp_stored), 64'd1);
        rd(16'h1010, 2'd3, d);
        chk("R4 hit value", d, 64'h0000_0077_55AA_55AA);
    endtask

    task automatic t_cswap_size;
        logic [63:0] d;
        send(CSWP, 16'h1010, 2'd0, 64'h11, 64'hAA, 1'b1, 1'b0);
        chk("R5 err flag", 64'(err_flag), 64'd1);
        chk("R5 no busy", 64'(busy), 64'd0);
        chk("R8 err data zero", rsp_data, 64'd0);
        send(CSWP, 16'h1010, 2'd1, 64'h11, 64'h55AA, 1'b1, 1'b0);
        chk("R5 err flag 2B", 64'(err_flag), 64'd1);
        rd(16'h1010, 2'd3, d);
        chk("R5 unchanged", d, 64'h0000_0077_55AA_55AA);
    endtask

    task automatic t_invalidate;
        logic [63:0] d;
        send(WINV, 16'h1008, 2'd3, 64'h0, '0, 1'b1, 1'b0);
        chk("R6 rsp", 64'(rsp_valid), 64'd1);
        chk("R6 data zero", rsp_data, 64'd0);
        chk("R6 no err", 64'(err_flag), 64'd0);
        send(INV, 16'h1008, 2'd3, 64'h0, '0, 1'b1, 1'b0);
        rd(16'h1008, 2'd3, d);
        chk("R6 unchanged", d, 64'hDEAD_BEEF_0000_0001);
    endtask

    task automatic t_inhibit;
        logic [63:0] d;
        send(WR, 16'h1008, 2'd3, 64'h0, '0, 1'b1, 1'b1);
        chk("R7 no rsp", 64'(rsp_valid), 64'd0);
        chk("R7 no err", 64'(err_flag), 64'd0);
        rd(16'h1008, 2'd3, d);
        chk("R7 unchanged", d, 64'hDEAD_BEEF_0000_0001);
    endtask

    task automatic t_badcmd;
        send(5'b00000, 16'h1008, 2'd3, '0, '0, 1'b1, 1'b0);
        chk("R8 empty cmd", 64'(err_flag), 64'd1);
        send(5'b00011, 16'h1008, 2'd3, '0, '0, 1'b1, 1'b0);
        chk("R8 read+write", 64'(err_flag), 64'd1);
        send(5'b10000, 16'h1008, 2'd3, '0, '0, 1'b0, 1'b0);
        chk("R8 cond alone", 64'(err_flag), 64'd1);
    endtask

    task automatic t_range;
        logic [63:0] d;
        wr(16'h1000, 2'd3, 64'hA5A5_0000_0000_5A5A);
        send(WR, 16'h1200, 2'd3, 64'h1, '0, 1'b0, 1'b0);
        chk("R9 above range err", 64'(err_flag), 64'd1);
        send(WR, 16'h0FF8, 2'd3, 64'h2, '0, 1'b0, 1'b0);
        chk("R9 below range err", 64'(err_flag), 64'd1);
        rd(16'h1000, 2'd3, d);
        chk("R9 index 0 intact", d, 64'hA5A5_0000_0000_5A5A);
        wr(16'h11F8, 2'd3, 64'h0BAD_F00D_1234_5678);
        chk("R9 last word ok", 64'(err_flag), 64'd0);
        rd(16'h11F8, 2'd3, d);
        chk("R9 last word", d, 64'h0BAD_F00D_1234_5678);
    endtask

    task automatic t_align;
        logic [63:0] d;
        send(WR, 16'h1002, 2'd2, 64'h3, '0, 1'b0, 1'b0);
        chk("R10 4B misaligned", 64'(err_flag), 64'd1);
        send(WR, 16'h1004, 2'd3, 64'h4, '0, 1'b0, 1'b0);
        chk("R10 8B misaligned", 64'(err_flag), 64'd1);
        send(WR, 16'h1001, 2'd1, 64'h5, '0, 1'b0, 1'b0);
        chk("R10 2B misaligned", 64'(err_flag), 64'd1);
        rd(16'h1000, 2'd3, d);
        chk("R10 unchanged", d, 64'hA5A5_0000_0000_5A5A);
    endtask

    task automatic t_busy;
        logic [63:0] d;
        wr(16'h1020, 2'd3, 64'h0101_0101_0101_0101);
        @(negedge clk);
        req_cmd = SWP; req_addr = 16'h1018; req_size = 2'd3;
        req_wdata = 64'h99; req_need_rsp = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        chk("R11 busy high", 64'(busy), 64'd1);
        req_cmd = WR; req_addr = 16'h1020; req_wdata = '1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 busy one cycle", 64'(busy), 64'd0);
        chk("R3 swap rsp under busy", 64'(rsp_valid), 64'd1);
        chk("R3 swap old zero", rsp_data, 64'd0);
        rd(16'h1020, 2'd3, d);
        chk("R11 write ignored", d, 64'h0101_0101_0101_0101);
        rd(16'h1018, 2'd3, d);
        chk("R3 swap wrote", d, 64'h99);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Scenario sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_write();
        t_need();
        t_swap();
        t_cswap();
        t_cswap_size();
        t_invalidate();
        t_inhibit();
        t_badcmd();
        t_range();
        t_align();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule